// File: doc/BRIEF.md
# Block Hamming ECC Engine

This engine sits on the byte stream of a NAND page transfer. It computes a single-error-correcting, double-error-detecting Hamming code over each 512-byte block. A page is handled as a run of up to four such blocks. Each block yields a 24-bit code word. On a write, the code word of every completed block is held on an output bus. The interface logic can then place the code words in the spare area, after the page data.

On a read, the data blocks are streamed through the same accumulator. The stored code words fetched from the spare area are then presented one block at a time on a check port. For each block, the engine forms the syndrome (stored XOR recomputed) and reports one of four outcomes:
- clean
- a single flipped data bit, with its byte offset and bit index
- an error in the stored code itself
- an uncorrectable pattern

A new page operation is announced by a start pulse that carries the low bits of the access address. The calculation is armed only when that address sits on a 512-byte boundary. The start pulse also clears every per-block result.

Top module: `hecc_engine`

## Requirements
- R1: After reset, and in the cycle after any `op_start`, `blk_done`, `res_valid`, `res_fix`, `res_fatal` and `res_codebad` are all zero.
- R2: Give data bit j of byte i in a block the 12-bit address a = i*8 + j. Then code bit 2k+1 is the XOR of all data bits with a[k]=1, and code bit 2k is the XOR of all data bits with a[k]=0, for k = 0..11.
- R3: Accepted bytes fill blocks 0, 1, 2, 3 in order. In the cycle after the 512th byte of block b is accepted, `blk_done[b]` is 1 and `code_words[24*b +: 24]` holds that block's code. Before that byte, `blk_done[b]` is 0.
- R4: If `op_start` arrives with `start_offs` not zero, no byte is accepted and no block completes until the next `op_start`.
- R5: Bytes after the fourth block are ignored, and the completed code words stay unchanged. A partly received block sets no `blk_done` bit.
- R6: In a read operation, a `chk_valid` for a completed block b with `chk_code` equal to the computed code sets `res_valid[b]` on the next cycle, with all three error flags at 0.
- R7: If the syndrome has exactly one bit of every pair (2k, 2k+1) set, `res_fix[b]` is set. The error location is `res_byte = a[11:3]` and `res_bit = a[2:0]`, where a[k] is syndrome bit 2k+1.
- R8: A syndrome with exactly one bit set sets `res_codebad[b]` only.
- R9: Any other non-zero syndrome, for example two flipped data bits, sets `res_fatal[b]` only.
- R10: `chk_valid` has no effect on a block that has not completed, and no effect during a write operation.
- R11: A byte presented in the same cycle as `op_start` is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Pulse: a new page operation begins |
| op_write | input | 1 | Operation kind with `op_start`: 1 write, 0 read |
| start_offs | input | 9 | Low address bits of the access start, sampled with `op_start` |
| byte_valid | input | 1 | A data byte is on `byte_data` |
| byte_data | input | 8 | Page data byte |
| chk_valid | input | 1 | A stored code word is on `chk_code` |
| chk_blk | input | 2 | Block index of the stored code word |
| chk_code | input | 24 | Stored code word read from the spare area |
| code_words | output | 96 | Computed code word of block b at bits 24*b +: 24 |
| blk_done | output | 4 | Block b has completed and its code word is valid |
| res_valid | output | 4 | Block b has a check result |
| res_fix | output | 4 | Block b holds one correctable data-bit error |
| res_fatal | output | 4 | Block b holds an uncorrectable error |
| res_codebad | output | 4 | Block b's stored code word has one flipped bit |
| res_byte | output | 36 | Error byte offset of block b at bits 9*b +: 9 |
| res_bit | output | 12 | Error bit index of block b at bits 3*b +: 3 |

## Verification
Write pages of all-zero, all-one, one-hot-per-byte and pseudo-random data are streamed. This separates row-parity faults from column-parity faults, because the all-one page makes every even-count parity collapse and the one-hot page drives each column pair alone. On a read, every one of the 4096 single data-bit positions of one block is injected through the stored code. Each of the 24 single code-bit flips and a set of two-bit data errors are injected as well. This tells a misplaced location bit from a wrong outcome class. Short, overlong, unaligned and start-cycle byte streams show whether block counting and arming follow the stream boundaries exactly.

// File: rtl/hecc_pkg.sv
// Package: shared outcome encoding for the block Hamming ECC engine.
package hecc_pkg;
    typedef enum logic [1:0] {
        CLS_CLEAN   = 2'd0,
        CLS_FIXABLE = 2'd1,
        CLS_FATAL   = 2'd2,
        CLS_CODEBAD = 2'd3
    } hecc_class_e;
endpackage

// File: rtl/hecc_accum.sv
// Module: hecc_accum
// Folds one byte per enabled cycle into the running line/column parity of
// the current block and counts bytes within the block.
// Assumes BLK_BYTES is a power of two; clr restarts the block from empty.
module hecc_accum #(
    parameter  int BLK_BYTES = 512,
    localparam int IDX_W     = $clog2(BLK_BYTES),
    localparam int ADDR_BITS = IDX_W + 3,
    localparam int CODE_W    = 2 * ADDR_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [7:0]        din,
    output logic              last,
    output logic [CODE_W-1:0] code_next
);
    logic [CODE_W-1:0] acc;
    logic [IDX_W-1:0]  cnt;
    logic              bpar;

    // Next parity value including the byte on din.
    always_comb begin
        code_next = acc;
        bpar      = ^din;
        for (int k = 0; k < 3; k++) begin
            for (int j = 0; j < 8; j++) begin
                if (((j >> k) & 1) == 1) code_next[2*k+1] = code_next[2*k+1] ^ din[j];
                else                     code_next[2*k]   = code_next[2*k]   ^ din[j];
            end
        end
        for (int k = 0; k < IDX_W; k++) begin
            if (cnt[k]) code_next[2*(k+3)+1] = code_next[2*(k+3)+1] ^ bpar;
            else        code_next[2*(k+3)]   = code_next[2*(k+3)]   ^ bpar;
        end
    end

    // Last byte of a block when the count sits at its top value.
    always_comb last = en && (cnt == IDX_W'(BLK_BYTES - 1));

    // Accumulator and byte counter update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
            cnt <= '0;
        end else if (en) begin
            acc <= last ? '0 : code_next;
            cnt <= cnt + 1'b1;
        end
    end

    a_r3_empty_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && acc == '0));
    a_r3_wrap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !clr) |=> (cnt == '0));
endmodule

// File: rtl/hecc_decode.sv
// Module: hecc_decode
// Classifies a syndrome into clean / single data bit / single code bit /
// uncorrectable and extracts the bit address from the odd syndrome bits.
// Purely combinational; assumes ADDR_BITS >= 2.
module hecc_decode
    import hecc_pkg::*;
#(
    parameter int ADDR_BITS = 12
) (
    input  logic [2*ADDR_BITS-1:0] syn,
    output hecc_class_e            cls,
    output logic [ADDR_BITS-1:0]   loc
);
    logic pair_ok;

    // Pair test, location extraction and class selection.
    always_comb begin
        pair_ok = 1'b1;
        for (int k = 0; k < ADDR_BITS; k++) begin
            pair_ok = pair_ok & (syn[2*k] ^ syn[2*k+1]);
            loc[k]  = syn[2*k+1];
        end
        if (syn == '0)                 cls = CLS_CLEAN;
        else if ($countones(syn) == 1) cls = CLS_CODEBAD;
        else if (pair_ok)              cls = CLS_FIXABLE;
        else                           cls = CLS_FATAL;
    end
endmodule

// File: rtl/hecc_slot.sv
// Module: hecc_slot
// Holds one block's computed code word and its check result.
// Assumes load and chk are never both asserted for the same block, and that
// clr (new page operation) wipes everything.
module hecc_slot
    import hecc_pkg::*;
#(
    parameter  int IDX_W     = 9,
    localparam int ADDR_BITS = IDX_W + 3,
    localparam int CODE_W    = 2 * ADDR_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [CODE_W-1:0] load_code,
    input  logic              chk,
    input  logic [CODE_W-1:0] chk_code,
    output logic              done,
    output logic [CODE_W-1:0] code,
    output logic              res_valid,
    output logic              res_fix,
    output logic              res_fatal,
    output logic              res_codebad,
    output logic [IDX_W-1:0]  res_byte,
    output logic [2:0]        res_bit
);
    hecc_class_e          cls;
    logic [ADDR_BITS-1:0] loc;
    logic                 take;

    hecc_decode #(.ADDR_BITS(ADDR_BITS)) dec_i (
        .syn (code ^ chk_code),
        .cls (cls),
        .loc (loc)
    );

    // A check counts only once the block's code is complete.
    always_comb take = chk && done;

    // Code word capture at block end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            done <= 1'b0;
            code <= '0;
        end else if (load) begin
            done <= 1'b1;
            code <= load_code;
        end
    end

    // Result capture on an accepted check.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            res_valid   <= 1'b0;
            res_fix     <= 1'b0;
            res_fatal   <= 1'b0;
            res_codebad <= 1'b0;
            res_byte    <= '0;
            res_bit     <= '0;
        end else if (take) begin
            res_valid   <= 1'b1;
            res_fix     <= (cls == CLS_FIXABLE);
            res_fatal   <= (cls == CLS_FATAL);
            res_codebad <= (cls == CLS_CODEBAD);
            res_byte    <= (cls == CLS_FIXABLE) ? loc[ADDR_BITS-1:3] : '0;
            res_bit     <= (cls == CLS_FIXABLE) ? loc[2:0] : 3'd0;
        end
    end

    a_r10_result_needs_code: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> done);
    a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_fix, res_fatal, res_codebad}));
    a_r7_fix_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clr && cls == CLS_FIXABLE) |=> res_fix);
    a_r8_single_bit_is_code: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clr && $countones(code ^ chk_code) == 1) |=> res_codebad);
endmodule

// File: rtl/hecc_engine.sv
// Module: hecc_engine (top)
// Per-512-byte Hamming ECC engine for a page of up to MAX_BLKS blocks.
// Arms on an aligned op_start, streams bytes into one accumulator, files
// each finished block's code into its slot, and checks stored codes on reads.
// Assumes MAX_BLKS >= 2 and BLK_BYTES a power of two.
module hecc_engine #(
    parameter  int BLK_BYTES = 512,
    parameter  int MAX_BLKS  = 4,
    localparam int IDX_W     = $clog2(BLK_BYTES),
    localparam int ADDR_BITS = IDX_W + 3,
    localparam int CODE_W    = 2 * ADDR_BITS,
    localparam int BI_W      = $clog2(MAX_BLKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       op_start,
    input  logic                       op_write,
    input  logic [IDX_W-1:0]           start_offs,
    input  logic                       byte_valid,
    input  logic [7:0]                 byte_data,
    input  logic                       chk_valid,
    input  logic [BI_W-1:0]            chk_blk,
    input  logic [CODE_W-1:0]          chk_code,
    output logic [MAX_BLKS*CODE_W-1:0] code_words,
    output logic [MAX_BLKS-1:0]        blk_done,
    output logic [MAX_BLKS-1:0]        res_valid,
    output logic [MAX_BLKS-1:0]        res_fix,
    output logic [MAX_BLKS-1:0]        res_fatal,
    output logic [MAX_BLKS-1:0]        res_codebad,
    output logic [MAX_BLKS*IDX_W-1:0]  res_byte,
    output logic [MAX_BLKS*3-1:0]      res_bit
);
    logic              armed;
    logic              wr_mode;
    logic [BI_W:0]     bcnt;
    logic              full;
    logic              accept;
    logic              last;
    logic [CODE_W-1:0] code_next;

    // Page is full once every block slot has completed.
    always_comb full = (bcnt == (BI_W+1)'(MAX_BLKS));
    // A byte is taken only while armed, outside the start cycle, below the cap.
    always_comb accept = armed && byte_valid && !op_start && !full;

    // Operation mode, arming and block index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            wr_mode <= 1'b0;
            bcnt    <= '0;
        end else if (op_start) begin
            armed   <= (start_offs == '0);
            wr_mode <= op_write;
            bcnt    <= '0;
        end else if (accept && last) begin
            bcnt    <= bcnt + 1'b1;
        end
    end

    hecc_accum #(.BLK_BYTES(BLK_BYTES)) acc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (op_start),
        .en        (accept),
        .din       (byte_data),
        .last      (last),
        .code_next (code_next)
    );

    for (genvar b = 0; b < MAX_BLKS; b++) begin : g_slot
        logic ld;
        logic ck;
        // Route the block-end load and the check strobe to slot b.
        always_comb begin
            ld = accept && last && (bcnt == (BI_W+1)'(b));
            ck = chk_valid && !wr_mode && !op_start && (chk_blk == BI_W'(b));
        end
        hecc_slot #(.IDX_W(IDX_W)) slot_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .clr         (op_start),
            .load        (ld),
            .load_code   (code_next),
            .chk         (ck),
            .chk_code    (chk_code),
            .done        (blk_done[b]),
            .code        (code_words[b*CODE_W +: CODE_W]),
            .res_valid   (res_valid[b]),
            .res_fix     (res_fix[b]),
            .res_fatal   (res_fatal[b]),
            .res_codebad (res_codebad[b]),
            .res_byte    (res_byte[b*IDX_W +: IDX_W]),
            .res_bit     (res_bit[b*3 +: 3])
        );
    end

    a_r1_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> (blk_done == '0 && res_valid == '0));
    a_r5_block_cap: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt <= (BI_W+1)'(MAX_BLKS));
    a_r4_idle_when_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !op_start) |=> $stable(blk_done));
    a_r3_one_more_done: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && last) |=> ($countones(blk_done) == $countones($past(blk_done)) + 1));
    a_r10_no_result_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode && !op_start) |=> $stable(res_valid));
endmodule

// File: tb/hecc_engine_tb_top.sv
// Bench: sweeps data patterns, stream lengths and every single-bit data
// error position of one block against arithmetically computed codes.
module hecc_engine_tb_top;
    localparam int NB = 4;
    localparam int BB = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_start = 1'b0;
    logic        op_write = 1'b0;
    logic [8:0]  start_offs = '0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        chk_valid = 1'b0;
    logic [1:0]  chk_blk = '0;
    logic [23:0] chk_code = '0;
    logic [95:0] code_words;
    logic [3:0]  blk_done, res_valid, res_fix, res_fatal, res_codebad;
    logic [35:0] res_byte;
    logic [11:0] res_bit;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [7:0] page [0:NB*BB-1];
    logic [31:0] lfsr = 32'hACE1_2468;

    always #10 clk = ~clk;

    hecc_engine dut_i (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_write(op_write),
        .start_offs(start_offs), .byte_valid(byte_valid), .byte_data(byte_data),
        .chk_valid(chk_valid), .chk_blk(chk_blk), .chk_code(chk_code),
        .code_words(code_words), .blk_done(blk_done), .res_valid(res_valid),
        .res_fix(res_fix), .res_fatal(res_fatal), .res_codebad(res_codebad),
        .res_byte(res_byte), .res_bit(res_bit)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Code contribution of one set data bit, from the R2 definition.
    function automatic logic [23:0] bit_code(int i, int j);
        logic [23:0] c = '0;
        int a = i * 8 + j;
        for (int k = 0; k < 12; k++) begin
            if (((a >> k) & 1) == 1) c[2*k+1] = 1'b1;
            else                     c[2*k]   = 1'b1;
        end
        return c;
    endfunction

    function automatic logic [23:0] ref_code(int blk);
        logic [23:0] c = '0;
        for (int i = 0; i < BB; i++)
            for (int j = 0; j < 8; j++)
                if (page[blk*BB + i][j]) c = c ^ bit_code(i, j);
        return c;
    endfunction

    task automatic fill(input int pat);
        for (int n = 0; n < NB*BB; n++) begin
            case (pat)
                0: page[n] = 8'h00;
                1: page[n] = 8'hFF;
                2: page[n] = 8'h01 << (n % 8);
                default: begin
                    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                    page[n] = lfsr[7:0] ^ lfsr[23:16];
                end
            endcase
        end
    endtask

    task automatic start_op(input logic w, input logic [8:0] offs);
        op_start = 1'b1; op_write = w; start_offs = offs;
        @(negedge clk);
        op_start = 1'b0;
    endtask

    task automatic feed(input int base, input int n);
        for (int k = 0; k < n; k++) begin
            byte_valid = 1'b1;
            byte_data  = page[(base + k) % (NB*BB)];
            @(negedge clk);
        end
        byte_valid = 1'b0;
    endtask

    task automatic do_chk(input int b, input logic [23:0] c);
        chk_valid = 1'b1; chk_blk = 2'(b); chk_code = c;
        @(negedge clk);
        chk_valid = 1'b0;
    endtask

    task automatic write_page(input int pat);
        fill(pat);
        start_op(1'b1, 9'd0);
        for (int b = 0; b < NB; b++) begin
            feed(b*BB, BB);
            check($sformatf("R3 done pat%0d blk%0d", pat, b), 64'(blk_done), 64'((1 << (b+1)) - 1));
            check($sformatf("R2 code pat%0d blk%0d", pat, b), 64'(code_words[b*24 +: 24]), 64'(ref_code(b)));
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [23:0] c2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset done",   64'(blk_done), 0);
        check("R1 reset result", 64'({res_valid, res_fix, res_fatal, res_codebad}), 0);

        // R2/R3: several write patterns
        for (int p = 0; p < 4; p++) write_page(p);

        // R1: new op clears
        start_op(1'b0, 9'd0);
        check("R1 clear on start", 64'(blk_done), 0);

        // R11: byte in start cycle ignored; R3 timing at 511/512
        fill(3);
        byte_valid = 1'b1; byte_data = 8'h5A;
        start_op(1'b1, 9'd0);
        byte_valid = 1'b0;
        feed(0, BB - 1);
        check("R3 not done at 511", 64'(blk_done), 0);
        feed(BB - 1, 1);
        check("R11 start byte skipped done", 64'(blk_done), 1);
        check("R11 start byte skipped code", 64'(code_words[23:0]), 64'(ref_code(0)));

        // R5: partial then overlong stream
        start_op(1'b1, 9'd0);
        feed(0, 300);
        check("R5 partial no done", 64'(blk_done), 0);
        feed(300, NB*BB - 300);
        check("R5 all done", 64'(blk_done), 64'hF);
        feed(0, BB);
        check("R5 extra bytes done", 64'(blk_done), 64'hF);
        for (int b = 0; b < NB; b++)
            check($sformatf("R5 code kept blk%0d", b), 64'(code_words[b*24 +: 24]), 64'(ref_code(b)));

        // R10: check during a write op has no effect
        do_chk(0, ~ref_code(0));
        check("R10 write op no result", 64'(res_valid), 0);

        // R4: unaligned start arms nothing
        start_op(1'b1, 9'd4);
        feed(0, BB);
        check("R4 unaligned no done", 64'(blk_done), 0);
        start_op(1'b1, 9'h100);
        feed(0, BB);
        check("R4 high offset no done", 64'(blk_done), 0);

        // Read operation
        start_op(1'b0, 9'd0);
        do_chk(0, 24'h0);
        check("R10 check before done", 64'(res_valid), 0);
        feed(0, NB*BB);
        for (int b = 0; b < NB; b++) begin
            do_chk(b, ref_code(b));
            check($sformatf("R6 clean valid blk%0d", b), 64'(res_valid[b]), 1);
            check($sformatf("R6 clean flags blk%0d", b),
                  64'({res_fix[b], res_fatal[b], res_codebad[b]}), 0);
        end

        // R7: every single data-bit position of block 2
        for (int i = 0; i < BB; i++) begin
            for (int j = 0; j < 8; j++) begin
                do_chk(2, ref_code(2) ^ bit_code(i, j));
                check($sformatf("R7 flags %0d.%0d", i, j),
                      64'({res_valid[2], res_fix[2], res_fatal[2], res_codebad[2]}), 64'b1100);
                check($sformatf("R7 byte %0d.%0d", i, j), 64'(res_byte[18 +: 9]), 64'(i));
                check($sformatf("R7 bit %0d.%0d", i, j),  64'(res_bit[6 +: 3]), 64'(j));
            end
        end

        // R8: every single code-bit flip of block 1
        for (int m = 0; m < 24; m++) begin
            do_chk(1, ref_code(1) ^ (24'h1 << m));
            check($sformatf("R8 code bit %0d", m),
                  64'({res_valid[1], res_fix[1], res_fatal[1], res_codebad[1]}), 64'b1001);
        end

        // R9: two flipped data bits in block 3
        c2 = ref_code(3);
        for (int t = 0; t < 64; t++) begin
            int i1 = (t * 37) % BB;
            int i2 = (t * 91 + 5) % BB;
            int j1 = t % 8;
            int j2 = (t * 3 + 1) % 8;
            if (i1 == i2 && j1 == j2) j2 = (j2 + 1) % 8;
            do_chk(3, c2 ^ bit_code(i1, j1) ^ bit_code(i2, j2));
            check($sformatf("R9 double %0d", t),
                  64'({res_valid[3], res_fix[3], res_fatal[3], res_codebad[3]}), 64'b1010);
        end

        // R1: next start clears read results
        start_op(1'b0, 9'd0);
        check("R1 results cleared", 64'({res_valid, res_fix, res_fatal, res_codebad}), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule